// File: doc/BRIEF.md
# Flash Sector Write-Protection Gate

This block stands between the command decoder of a serial NOR flash and its storage array. For every program, sector-erase or bulk-erase request it decides whether the array may be modified. The decision depends on the current status byte and the target byte address. A granted request drives the array's write strobe. A denied request raises a one-cycle error pulse and the array is left untouched.

The protected region is set by a four-bit protection level and one anchor bit, all taken from the status byte. The four level bits do not sit next to each other in that byte. Level 0 leaves the whole array open. A nonzero level n covers a power-of-two number of 64 KB sectors, 2^(n-1), capped at the full array of 512 sectors. The anchor bit places that span at the high end of the array or at the low end. The decision is registered and arrives one cycle after the request.

Top module: `flash_guard`

## Requirements
- R1: The protection level is {status[6], status[4], status[3], status[2]}, with status[6] as its most significant bit. status[5] is the anchor bit. Status bits 7, 1 and 0 have no effect on any decision.
- R2: With level 0, every program, sector erase and bulk erase is granted at any address.
- R3: A level n from 1 to 15 protects exactly min(2^(n-1), 512) sectors.
- R4: With status[5] = 0 (high anchoring), the protected sectors run from 512 minus the count up to 511.
- R5: With status[5] = 1 (low anchoring), the protected sectors run from 0 up to the count minus 1.
- R6: The sector index is addr[24:16]. Address bits 15:0 have no effect on the decision.
- R7: Program (op 2'b00) and sector erase (op 2'b01) are denied when the target sector is protected and granted otherwise.
- R8: Bulk erase (op 2'b10) is granted only when the level is 0 and is denied for any nonzero level, whatever the address.
- R9: A request with req_valid_i high in the cycle before a rising edge produces exactly one of grant_o or blocked_o, high for the single cycle after that edge. The two outputs are never high together.
- R10: A cycle without req_valid_i, or a request with the reserved op 2'b11, leaves both outputs low in the following cycle.
- R11: While rst_n is low, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | A modify request is presented this cycle |
| req_op_i | input | 2 | 00 program, 01 sector erase, 10 bulk erase, 11 reserved |
| status_i | input | 8 | Current status byte holding the level and anchor bits |
| addr_i | input | 25 | Target byte address |
| grant_o | output | 1 | One-cycle pulse: the request may modify the array |
| blocked_o | output | 1 | One-cycle pulse: the request was refused |

## Verification
A fault in the level decoder shows up at the ports as a protected span of the wrong size or on the wrong side. It appears as a grant or a block on the wrong side of a boundary sector, one cycle after the request. For this reason the bench probes the sectors on both sides of each boundary, for every level and both anchors. A fault in the output register, such as a stuck or stretched pulse, shows up one cycle later as a second pulse or as a missing pulse. Back-to-back requests and idle cycles expose it.

// File: rtl/flg_pkg.sv
package flg_pkg;

  typedef enum logic [1:0] {
    OP_PROGRAM  = 2'b00,
    OP_SECERASE = 2'b01,
    OP_BULKERASE = 2'b10,
    OP_RESERVED = 2'b11
  } flg_op_e;

  localparam int LEVEL_W = 4;

  // The level bits are scattered across the status byte: three adjacent
  // bits form the low part, one separate bit forms the top.
  localparam int LVL_LO_POS = 2;
  localparam int LVL_HI_POS = 6;
  localparam int ANCHOR_POS = 5;

  function automatic logic [LEVEL_W-1:0] level_of(input logic [7:0] st);
    return {st[LVL_HI_POS], st[LVL_LO_POS+2:LVL_LO_POS]};
  endfunction

  function automatic logic anchor_low(input logic [7:0] st);
    return st[ANCHOR_POS];
  endfunction

endpackage

// File: rtl/flg_level_decode.sv
module flg_level_decode
  import flg_pkg::*;
#(
  parameter int SECT_BITS = 9
) (
  input  logic [7:0]           status_i,
  output logic [LEVEL_W-1:0]   level_o,
  output logic                 low_anchor_o,
  output logic [SECT_BITS:0]   count_o
);
  localparam int CNT_W = SECT_BITS + 1;
  localparam int NSECT = 1 << SECT_BITS;

  // Sectors covered by a level: zero for level 0, otherwise 2^(n-1)
  // saturated at the array size.
  function automatic logic [CNT_W-1:0] span_of(input logic [LEVEL_W-1:0] lvl);
    if (lvl == '0) return '0;
    if (int'(lvl) - 1 >= SECT_BITS) return CNT_W'(NSECT);
    return CNT_W'(1) << (lvl - LEVEL_W'(1));
  endfunction

  logic unused_status_bits;
  assign unused_status_bits = ^{status_i[7], status_i[1:0]};

  assign level_o      = level_of(status_i);
  assign low_anchor_o = anchor_low(status_i);
  assign count_o      = span_of(level_o);

endmodule

// File: rtl/flg_region_match.sv
module flg_region_match #(
  parameter int SECT_BITS = 9
) (
  input  logic [SECT_BITS-1:0] sector_i,
  input  logic [SECT_BITS:0]   count_i,
  input  logic                 low_anchor_i,
  output logic                 hit_o
);
  localparam int CNT_W = SECT_BITS + 1;
  localparam int NSECT = 1 << SECT_BITS;

  logic [CNT_W-1:0] sec_w;
  logic [CNT_W-1:0] high_base;
  logic             in_low;
  logic             in_high;

  assign sec_w     = {1'b0, sector_i};
  assign high_base = CNT_W'(NSECT) - count_i;
  assign in_low    = sec_w < count_i;
  assign in_high   = sec_w >= high_base;
  assign hit_o     = low_anchor_i ? in_low : in_high;

endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flg_pkg::*;
#(
  parameter int SECT_BITS = 9,
  parameter int OFS_BITS  = 16,
  localparam int ADDR_W   = SECT_BITS + OFS_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic [7:0]        status_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              grant_o,
  output logic              blocked_o
);
  localparam int NSECT = 1 << SECT_BITS;

  logic [LEVEL_W-1:0]   level;
  logic                 low_anchor;
  logic [SECT_BITS:0]   prot_count;
  logic [SECT_BITS-1:0] sector;
  logic                 sector_hit;
  logic                 level_nz;
  logic                 op_known;
  logic                 deny_now;
  logic                 allow_now;
  flg_op_e              op;

  logic unused_addr_offset;
  assign unused_addr_offset = ^addr_i[OFS_BITS-1:0];

  assign op     = flg_op_e'(req_op_i);
  assign sector = addr_i[ADDR_W-1:OFS_BITS];

  flg_level_decode #(.SECT_BITS(SECT_BITS)) u_decode (
    .status_i     (status_i),
    .level_o      (level),
    .low_anchor_o (low_anchor),
    .count_o      (prot_count)
  );

  flg_region_match #(.SECT_BITS(SECT_BITS)) u_match (
    .sector_i     (sector),
    .count_i      (prot_count),
    .low_anchor_i (low_anchor),
    .hit_o        (sector_hit)
  );

  assign level_nz = level != '0;
  assign op_known = op != OP_RESERVED;

  always_comb begin
    deny_now = 1'b0;
    unique case (op)
      OP_PROGRAM, OP_SECERASE: deny_now = sector_hit;
      OP_BULKERASE:            deny_now = level_nz;
      default:                 deny_now = 1'b0;
    endcase
  end

  assign allow_now = op_known && !deny_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_o   <= 1'b0;
      blocked_o <= 1'b0;
    end else begin
      grant_o   <= req_valid_i && allow_now;
      blocked_o <= req_valid_i && op_known && deny_now;
    end
  end

  AST_ONE_HOT_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant_o && blocked_o)); // R9
  AST_ALWAYS_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_op_i != 2'b11) |=> (grant_o || blocked_o)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid_i |=> (!grant_o && !blocked_o)); // R10
  AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_op_i == 2'b11) |=> (!grant_o && !blocked_o)); // R10
  AST_BULK_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_op_i == 2'b10 && level != '0) |=> blocked_o); // R8
  AST_LEVEL_ZERO_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_op_i != 2'b11 && level == '0) |=> grant_o); // R2
  AST_COUNT_POW2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(prot_count) <= 1); // R3
  AST_COUNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    int'(prot_count) <= NSECT); // R3

endmodule

// File: tb/flash_guard_test.sv
module flash_guard_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [1:0]  req_op_i = 2'b00;
  logic [7:0]  status_i = 8'h00;
  logic [24:0] addr_i = '0;
  logic        grant_o;
  logic        blocked_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  flash_guard uut (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .req_op_i(req_op_i),
    .status_i(status_i), .addr_i(addr_i), .grant_o(grant_o), .blocked_o(blocked_o)
  );

  // {status, addr, op, expected {grant, blocked}}
  localparam int NV = 19;
  localparam logic [36:0] VEC [NV] = '{
    {8'h00, 25'h1FF0000, 2'b00, 2'b10},  // R2 level 0, last sector
    {8'h04, 25'h1FF0000, 2'b00, 2'b01},  // R4 level 1 high: sector 511
    {8'h04, 25'h1FE0000, 2'b00, 2'b10},  // R4 sector 510 open
    {8'h24, 25'h0000000, 2'b00, 2'b01},  // R5 level 1 low: sector 0
    {8'h24, 25'h0010000, 2'b00, 2'b10},  // R5 sector 1 open
    {8'h10, 25'h1F80000, 2'b01, 2'b01},  // R7 level 4 high: sector 504
    {8'h10, 25'h1F70000, 2'b01, 2'b10},  // R7 sector 503 open
    {8'h30, 25'h007FFFF, 2'b00, 2'b01},  // R6 level 4 low: sector 7, offset ffff
    {8'h30, 25'h0080000, 2'b00, 2'b10},  // R5 sector 8 open
    {8'h48, 25'h0000000, 2'b00, 2'b01},  // R3 level 10 saturates: all
    {8'h7C, 25'h1FF0000, 2'b01, 2'b01},  // R3 level 15 low: all
    {8'h44, 25'h0FF0000, 2'b00, 2'b10},  // R3 level 9 high: sector 255 open
    {8'h44, 25'h1000000, 2'b00, 2'b01},  // R3 sector 256 protected
    {8'h83, 25'h1230000, 2'b10, 2'b10},  // R1 R8 bulk at level 0, stray bits
    {8'h04, 25'h0000000, 2'b10, 2'b01},  // R8 bulk at level 1
    {8'h04, 25'h1FF0000, 2'b11, 2'b00},  // R10 reserved op
    {8'h60, 25'h07F0000, 2'b00, 2'b01},  // R5 level 8 low: sector 127
    {8'h60, 25'h0800000, 2'b00, 2'b10},  // R5 sector 128 open
    {8'h87, 25'h1FF0000, 2'b00, 2'b01}   // R1 stray bits ignored, level 1
  };

  task automatic check(input string tag, input logic [1:0] got, input logic [1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: {grant,blocked} actual %b expected %b", tag, got, exp);
    end
  endtask

  task automatic issue(input logic [7:0] st, input logic [24:0] a, input logic [1:0] op);
    @(negedge clk);
    status_i = st; addr_i = a; req_op_i = op; req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
  endtask

  // Independent statement of the protected span.
  function automatic bit is_prot(input logic [7:0] st, input int sec);
    int lvl, cnt;
    lvl = st[6] * 8 + st[4] * 4 + st[3] * 2 + st[2];
    if (lvl == 0) return 0;
    cnt = (lvl > 9) ? 512 : (1 << (lvl - 1));
    if (st[5]) return sec < cnt;
    return sec + cnt >= 512;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    req_valid_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 reset holds outputs low", {grant_o, blocked_o}, 2'b00);
    req_valid_i = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 idle after reset", {grant_o, blocked_o}, 2'b00);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][36:29], VEC[i][28:4], VEC[i][3:2]);
      check($sformatf("vector %0d R3 R4 R5 R7", i), {grant_o, blocked_o}, VEC[i][1:0]);
    end

    // Boundary sweep over every level and both anchors (R3 R4 R5 R7)
    for (int lvl = 0; lvl < 16; lvl++) begin
      for (int b = 0; b < 2; b++) begin
        logic [7:0] st;
        int cnt;
        st = {1'b0, 1'(lvl >> 3), 1'(b), 3'(lvl), 2'b00};
        cnt = (lvl == 0) ? 0 : ((lvl > 9) ? 512 : (1 << (lvl - 1)));
        for (int k = 0; k < 6; k++) begin
          int sec;
          logic [1:0] exp;
          case (k)
            0: sec = 0;
            1: sec = 511;
            2: sec = cnt - 1;
            3: sec = cnt;
            4: sec = 511 - cnt;
            default: sec = 512 - cnt;
          endcase
          if (sec < 0 || sec > 511) continue;
          exp = is_prot(st, sec) ? 2'b01 : 2'b10;
          issue(st, {9'(sec), 16'h5A5A}, 2'(k & 1));
          check($sformatf("sweep R3 R4 R5 lvl %0d low %0d sec %0d", lvl, b, sec),
                {grant_o, blocked_o}, exp);
        end
        issue(st, 25'h0, 2'b10);
        check($sformatf("R8 bulk lvl %0d", lvl), {grant_o, blocked_o},
              (lvl == 0) ? 2'b10 : 2'b01);
      end
    end

    // R6: offset bits alone never change the outcome at a boundary
    issue(8'h04, 25'h1FEFFFF, 2'b00);
    check("R6 sector 510 top offset", {grant_o, blocked_o}, 2'b10);
    issue(8'h04, 25'h1FF0000, 2'b00);
    check("R6 sector 511 zero offset", {grant_o, blocked_o}, 2'b01);

    // R9: back-to-back requests give one pulse each
    @(negedge clk);
    status_i = 8'h04; addr_i = 25'h1FF0000; req_op_i = 2'b00; req_valid_i = 1'b1;
    @(negedge clk);
    addr_i = 25'h0000000;
    check("R9 first of pair blocked", {grant_o, blocked_o}, 2'b01);
    @(negedge clk);
    req_valid_i = 1'b0;
    check("R9 second of pair granted", {grant_o, blocked_o}, 2'b10);
    @(negedge clk);
    check("R9 R10 pulse ends", {grant_o, blocked_o}, 2'b00);

    // R11: reset during a request suppresses the answer
    @(negedge clk);
    req_valid_i = 1'b1; rst_n = 1'b0;
    @(negedge clk);
    check("R11 reset during request", {grant_o, blocked_o}, 2'b00);
    req_valid_i = 1'b0; rst_n = 1'b1;
    @(negedge clk);
    check("R10 quiet after reset release", {grant_o, blocked_o}, 2'b00);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule